// File: doc/BRIEF.md
# Windowed Call and Return Controller

This block handles the register-window side of subroutine linkage in a core with a rotating register file. It has a physical file of `NAREG` registers, grouped into frames of four, and a visible window of sixteen logical registers. The controller owns three pieces of state: the window base (the frame at which the visible window starts), a bitmask with one bit for each frame that is set while that frame holds a live activation, and the pending call increment.

Each cycle the core may present one operation: a windowed call, a frame entry, a windowed return, or a stack-pointer move check. The core supplies the current PC, the decoded instruction fields and the register values the operation needs. One cycle later the controller answers with:
- a register-file write command (logical index and data),
- the updated base and mask,
- an exception request with its cause, faulting PC and saved old base, or
- a jump request with the return address.

Spilling frames to memory is left to the exception handlers that the requests start.

Top module: `win_call_ctrl`

## Requirements
- R1: After reset the base is 0, the live mask is 1 (only frame 0 live) and the pending increment is 0. No write, exception or jump is asserted.
- R2: A call (op 0) with increment k in 1..3 stores k as the pending increment and writes logical register 4*k with {k, next_pc[29:0]}.
- R3: A call with increment 0, and any other illegal operation, raises cause 1 (illegal) with the exception PC equal to the PC. It performs no write, no jump and no change of state.
- R4: An entry (op 1) is illegal when the source index is above 3. It is also illegal unless the overflow-enable input is 1 and the exception-mode input is 0.
- R5: A legal entry writes logical register {pending increment, s[1:0]} with the source value minus imm12*8. It adds the pending increment to the base and sets the mask bit at the new base.
- R6: For a return (op 2), n is link[31:30]. m is 1, 2 or 3 for the first set mask bit found at base-1, base-2 and base-3, checked in that order, and 0 if none is set. The return is illegal when n is 0, when m is non-zero and differs from n, or when the mode inputs are not 1 and 0.
- R7: A legal return whose frame at base-n is live sets the base to base-n, clears the mask bit at the old base, and jumps to {pc[31:30], link[29:0]}.
- R8: A legal return whose frame at base-n is not live still sets the base to base-n and leaves the mask unchanged. It raises underflow cause 3, 4 or 5 for n equal to 1, 2 or 3, with the old base on the saved-base output and the PC as the exception PC.
- R9: A stack-pointer move check (op 3) raises cause 2 (alloca) when the mask bits at base-1, base-2 and base-3 are all clear. Otherwise it does nothing.
- R10: All base arithmetic and mask indexing wrap modulo the frame count NAREG/4.
- R11: Every result appears in the cycle after the operation is presented. A cycle with no valid operation asserts no write, exception or jump and leaves base, mask and pending increment unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 2 | 0 call, 1 entry, 2 return, 3 stack-pointer move check |
| call_inc_i | input | 2 | Call increment for op 0 |
| pc_i | input | 32 | PC of the operation |
| next_pc_i | input | 32 | PC of the following instruction (for calls) |
| src_idx_i | input | 4 | Entry source register index s |
| imm12_i | input | 12 | Entry frame-size immediate |
| src_val_i | input | 32 | Value of logical register s |
| link_i | input | 32 | Value of logical register 0 |
| woe_i | input | 1 | Window overflow enable status bit |
| excm_i | input | 1 | Exception mode status bit |
| rf_we_o | output | 1 | Register-file write request |
| rf_waddr_o | output | 4 | Logical register index to write |
| rf_wdata_o | output | 32 | Write data |
| base_o | output | $clog2(NAREG/4) | Current window base |
| wstart_o | output | NAREG/4 | Live-frame mask |
| callinc_o | output | 2 | Pending call increment |
| exc_o | output | 1 | Exception request |
| exc_cause_o | output | 3 | 1 illegal, 2 alloca, 3/4/5 underflow of 4/8/12 |
| exc_pc_o | output | 32 | Faulting PC |
| owb_o | output | $clog2(NAREG/4) | Base before the underflowing return |
| jump_o | output | 1 | Return jump request |
| jump_pc_o | output | 32 | Return address |

## Verification
Every output, including the state outputs base, mask and pending increment, is registered at the single clock edge that follows the cycle in which the operation is presented. The bench drives each operation on a falling edge and works out the expected results from its own model of the state. It compares all outputs on the next falling edge, which lies half a period after the updating edge, and only then drives the next operation. Idle cycles are checked the same way: the pulse outputs must read zero and the state must read the same as one cycle earlier.

// File: rtl/win_call_pkg.sv
package win_call_pkg;
  typedef enum logic [1:0] {
    OP_CALL  = 2'd0,
    OP_ENTRY = 2'd1,
    OP_RET   = 2'd2,
    OP_MOVSP = 2'd3
  } win_op_e;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_ILLEGAL = 3'd1,
    CAUSE_ALLOCA  = 3'd2,
    CAUSE_UF4     = 3'd3,
    CAUSE_UF8     = 3'd4,
    CAUSE_UF12    = 3'd5
  } win_cause_e;

  localparam int unsigned XLEN = 32;
endpackage

// File: rtl/win_frame_probe.sv
module win_frame_probe #(
  parameter int unsigned NF = 16,
  parameter int unsigned BW = $clog2(NF)
) (
  input  logic [NF-1:0] mask_i,
  input  logic [BW-1:0] base_i,
  output logic [2:0]    below_o,
  output logic [1:0]    m_o
);
  // live bits of the three frames under the base, wrapping modulo NF
  for (genvar k = 1; k <= 3; k++) begin : g_below
    logic [BW-1:0] idx;
    assign idx          = base_i - BW'(k);
    assign below_o[k-1] = mask_i[idx];
  end

  always_comb begin
    if (below_o[0])      m_o = 2'd1;
    else if (below_o[1]) m_o = 2'd2;
    else if (below_o[2]) m_o = 2'd3;
    else                 m_o = 2'd0;
  end
endmodule

// File: rtl/win_call_exec.sv
module win_call_exec
  import win_call_pkg::*;
#(
  parameter int unsigned NF = 16,
  parameter int unsigned BW = $clog2(NF)
) (
  input  logic            op_valid_i,
  input  logic [1:0]      op_i,
  input  logic [1:0]      call_inc_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] next_pc_i,
  input  logic [3:0]      src_idx_i,
  input  logic [11:0]     imm12_i,
  input  logic [XLEN-1:0] src_val_i,
  input  logic [XLEN-1:0] link_i,
  input  logic            woe_i,
  input  logic            excm_i,
  input  logic [BW-1:0]   base_i,
  input  logic [NF-1:0]   ws_i,
  input  logic [1:0]      ci_i,
  output logic [BW-1:0]   base_o,
  output logic [NF-1:0]   ws_o,
  output logic [1:0]      ci_o,
  output logic            we_o,
  output logic [3:0]      waddr_o,
  output logic [XLEN-1:0] wdata_o,
  output logic            exc_o,
  output logic [2:0]      cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [BW-1:0]   owb_o,
  output logic            jmp_o,
  output logic [XLEN-1:0] jpc_o
);
  logic [2:0]    below;
  logic [1:0]    m;
  logic [1:0]    n;
  logic          mode_ok;
  logic [BW-1:0] ent_base;
  logic [BW-1:0] ret_base;
  logic          ret_bad;

  win_frame_probe #(.NF(NF), .BW(BW)) u_probe (
    .mask_i (ws_i),
    .base_i (base_i),
    .below_o(below),
    .m_o    (m)
  );

  assign n        = link_i[XLEN-1:XLEN-2];
  assign mode_ok  = woe_i & ~excm_i;
  assign ent_base = base_i + BW'(ci_i);
  assign ret_base = base_i - BW'(n);
  assign ret_bad  = (n == 2'd0) || ((m != 2'd0) && (m != n)) || !mode_ok;

  always_comb begin
    base_o  = base_i;
    ws_o    = ws_i;
    ci_o    = ci_i;
    we_o    = 1'b0;
    waddr_o = '0;
    wdata_o = '0;
    exc_o   = 1'b0;
    cause_o = CAUSE_NONE;
    epc_o   = '0;
    owb_o   = '0;
    jmp_o   = 1'b0;
    jpc_o   = '0;
    if (op_valid_i) begin
      unique case (win_op_e'(op_i))
        OP_CALL: begin
          if (call_inc_i == 2'd0) begin
            exc_o = 1'b1; cause_o = CAUSE_ILLEGAL; epc_o = pc_i;
          end else begin
            ci_o    = call_inc_i;
            we_o    = 1'b1;
            waddr_o = {call_inc_i, 2'b00};
            wdata_o = {call_inc_i, next_pc_i[XLEN-3:0]};
          end
        end
        OP_ENTRY: begin
          if (src_idx_i[3:2] != 2'b00 || !mode_ok) begin
            exc_o = 1'b1; cause_o = CAUSE_ILLEGAL; epc_o = pc_i;
          end else begin
            we_o    = 1'b1;
            waddr_o = {ci_i, src_idx_i[1:0]};
            wdata_o = src_val_i - XLEN'({imm12_i, 3'b000});
            base_o  = ent_base;
            ws_o    = ws_i | (NF'(1) << ent_base);
          end
        end
        OP_RET: begin
          if (ret_bad) begin
            exc_o = 1'b1; cause_o = CAUSE_ILLEGAL; epc_o = pc_i;
          end else begin
            base_o = ret_base;
            if (ws_i[ret_base]) begin
              ws_o  = ws_i & ~(NF'(1) << base_i);
              jmp_o = 1'b1;
              jpc_o = {pc_i[XLEN-1:XLEN-2], link_i[XLEN-3:0]};
            end else begin
              exc_o   = 1'b1;
              cause_o = (n == 2'd1) ? CAUSE_UF4 : (n == 2'd2) ? CAUSE_UF8 : CAUSE_UF12;
              owb_o   = base_i;
              epc_o   = pc_i;
            end
          end
        end
        OP_MOVSP: begin
          if (below == 3'b000) begin
            exc_o = 1'b1; cause_o = CAUSE_ALLOCA; epc_o = pc_i;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/win_call_ctrl.sv
module win_call_ctrl
  import win_call_pkg::*;
#(
  parameter int unsigned NAREG = 64,
  localparam int unsigned NF   = NAREG / 4,
  localparam int unsigned BW   = $clog2(NF)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [1:0]      op_i,
  input  logic [1:0]      call_inc_i,
  input  logic [31:0]     pc_i,
  input  logic [31:0]     next_pc_i,
  input  logic [3:0]      src_idx_i,
  input  logic [11:0]     imm12_i,
  input  logic [31:0]     src_val_i,
  input  logic [31:0]     link_i,
  input  logic            woe_i,
  input  logic            excm_i,
  output logic            rf_we_o,
  output logic [3:0]      rf_waddr_o,
  output logic [31:0]     rf_wdata_o,
  output logic [BW-1:0]   base_o,
  output logic [NF-1:0]   wstart_o,
  output logic [1:0]      callinc_o,
  output logic            exc_o,
  output logic [2:0]      exc_cause_o,
  output logic [31:0]     exc_pc_o,
  output logic [BW-1:0]   owb_o,
  output logic            jump_o,
  output logic [31:0]     jump_pc_o
);
  logic [BW-1:0]   base_d;
  logic [NF-1:0]   ws_d;
  logic [1:0]      ci_d;
  logic            we_d, exc_d, jmp_d;
  logic [3:0]      waddr_d;
  logic [XLEN-1:0] wdata_d, epc_d, jpc_d;
  logic [2:0]      cause_d;
  logic [BW-1:0]   owb_d;

  win_call_exec #(.NF(NF), .BW(BW)) u_exec (
    .op_valid_i(op_valid_i),
    .op_i      (op_i),
    .call_inc_i(call_inc_i),
    .pc_i      (pc_i),
    .next_pc_i (next_pc_i),
    .src_idx_i (src_idx_i),
    .imm12_i   (imm12_i),
    .src_val_i (src_val_i),
    .link_i    (link_i),
    .woe_i     (woe_i),
    .excm_i    (excm_i),
    .base_i    (base_o),
    .ws_i      (wstart_o),
    .ci_i      (callinc_o),
    .base_o    (base_d),
    .ws_o      (ws_d),
    .ci_o      (ci_d),
    .we_o      (we_d),
    .waddr_o   (waddr_d),
    .wdata_o   (wdata_d),
    .exc_o     (exc_d),
    .cause_o   (cause_d),
    .epc_o     (epc_d),
    .owb_o     (owb_d),
    .jmp_o     (jmp_d),
    .jpc_o     (jpc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o      <= '0;
      wstart_o    <= NF'(1);
      callinc_o   <= '0;
      rf_we_o     <= 1'b0;
      rf_waddr_o  <= '0;
      rf_wdata_o  <= '0;
      exc_o       <= 1'b0;
      exc_cause_o <= CAUSE_NONE;
      exc_pc_o    <= '0;
      owb_o       <= '0;
      jump_o      <= 1'b0;
      jump_pc_o   <= '0;
    end else begin
      base_o      <= base_d;
      wstart_o    <= ws_d;
      callinc_o   <= ci_d;
      rf_we_o     <= we_d;
      rf_waddr_o  <= waddr_d;
      rf_wdata_o  <= wdata_d;
      exc_o       <= exc_d;
      exc_cause_o <= cause_d;
      exc_pc_o    <= epc_d;
      owb_o       <= owb_d;
      jump_o      <= jmp_d;
      jump_pc_o   <= jpc_d;
    end
  end
endmodule

// File: rtl/win_call_chk.sv
module win_call_chk #(
  parameter int unsigned NF = 16,
  parameter int unsigned BW = $clog2(NF)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          op_valid_i,
  input logic [1:0]    op_i,
  input logic [1:0]    call_inc_i,
  input logic [3:0]    src_idx_i,
  input logic          rf_we_o,
  input logic [BW-1:0] base_o,
  input logic [NF-1:0] wstart_o,
  input logic [1:0]    callinc_o,
  input logic          exc_o,
  input logic [2:0]    exc_cause_o,
  input logic [BW-1:0] owb_o,
  input logic          jump_o
);
  assert_live_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wstart_o != '0);

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(base_o) && $stable(wstart_o) && !rf_we_o && !exc_o && !jump_o);

  assert_entry_bad_idx_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'd1 && src_idx_i > 4'd3) |=> exc_o && exc_cause_o == 3'd1);

  assert_exc_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !rf_we_o && !jump_o);

  assert_uf_rotated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o && exc_cause_o >= 3'd3) |-> base_o != owb_o);

  assert_call_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'd0 && call_inc_i != 2'd0) |=> rf_we_o && callinc_o == $past(call_inc_i));
endmodule

bind win_call_ctrl win_call_chk #(.NF(NF), .BW(BW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_i       (op_i),
  .call_inc_i (call_inc_i),
  .src_idx_i  (src_idx_i),
  .rf_we_o    (rf_we_o),
  .base_o     (base_o),
  .wstart_o   (wstart_o),
  .callinc_o  (callinc_o),
  .exc_o      (exc_o),
  .exc_cause_o(exc_cause_o),
  .owb_o      (owb_o),
  .jump_o     (jump_o)
);

// File: tb/win_call_ctrl_tb.sv
module win_call_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op = '0, cinc = '0;
  logic [31:0] pc = '0, npc = '0, sval = '0, link = '0;
  logic [3:0]  sidx = '0;
  logic [11:0] imm = '0;
  logic        woe = 1'b1, excm = 1'b0;
  logic        rf_we, exc, jmp;
  logic [3:0]  waddr;
  logic [31:0] wdata, epc, jpc;
  logic [3:0]  base, owb;
  logic [15:0] ws;
  logic [1:0]  ci;
  logic [2:0]  cause;

  int total = 0, bad = 0, dummy;

  logic [3:0]  m_base;
  logic [15:0] m_ws;
  logic [1:0]  m_ci;
  logic        e_we, e_exc, e_jmp;
  logic [3:0]  e_waddr, e_owb;
  logic [31:0] e_wdata, e_epc, e_jpc;
  logic [2:0]  e_cause;
  string       tag;

  always #5 clk = ~clk;

  win_call_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .call_inc_i(cinc), .pc_i(pc), .next_pc_i(npc), .src_idx_i(sidx),
    .imm12_i(imm), .src_val_i(sval), .link_i(link), .woe_i(woe), .excm_i(excm),
    .rf_we_o(rf_we), .rf_waddr_o(waddr), .rf_wdata_o(wdata), .base_o(base),
    .wstart_o(ws), .callinc_o(ci), .exc_o(exc), .exc_cause_o(cause),
    .exc_pc_o(epc), .owb_o(owb), .jump_o(jmp), .jump_pc_o(jpc)
  );

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic model();
    logic [1:0] n, m;
    logic [3:0] nb;
    logic ok;
    e_we = 0; e_exc = 0; e_jmp = 0; e_waddr = 0; e_owb = 0;
    e_wdata = 0; e_epc = 0; e_jpc = 0; e_cause = 0;
    ok = woe && !excm;
    if (!op_valid) begin tag = "R11"; return; end
    case (op)
      2'd0: if (cinc == 0) begin tag = "R3"; e_exc = 1; e_cause = 1; e_epc = pc; end
            else begin tag = "R2"; m_ci = cinc; e_we = 1; e_waddr = {cinc, 2'b00};
              e_wdata = {cinc, npc[29:0]}; end
      2'd1: if (sidx > 3 || !ok) begin tag = "R4"; e_exc = 1; e_cause = 1; e_epc = pc; end
            else begin tag = "R5"; e_we = 1; e_waddr = {m_ci, sidx[1:0]};
              e_wdata = sval - {17'd0, imm, 3'd0}; m_base = m_base + {2'b00, m_ci};
              m_ws[m_base] = 1'b1; end
      2'd2: begin
        n = link[31:30];
        m = m_ws[m_base - 4'd1] ? 2'd1 : m_ws[m_base - 4'd2] ? 2'd2 :
            m_ws[m_base - 4'd3] ? 2'd3 : 2'd0;
        if (n == 0 || (m != 0 && m != n) || !ok) begin
          tag = "R6"; e_exc = 1; e_cause = 1; e_epc = pc;
        end else begin
          nb = m_base - {2'b00, n};
          if (m_ws[nb]) begin
            tag = "R7"; m_ws[m_base] = 1'b0; e_jmp = 1; e_jpc = {pc[31:30], link[29:0]};
          end else begin
            tag = "R8"; e_exc = 1; e_cause = 3'd2 + {1'b0, n}; e_owb = m_base; e_epc = pc;
          end
          m_base = nb;
        end
      end
      default: begin
        tag = "R9";
        if (!m_ws[m_base - 4'd1] && !m_ws[m_base - 4'd2] && !m_ws[m_base - 4'd3]) begin
          e_exc = 1; e_cause = 2; e_epc = pc;
        end
      end
    endcase
  endtask

  task automatic compare(string t);
    chk(t, "we", 32'(rf_we), 32'(e_we));
    chk(t, "exc", 32'(exc), 32'(e_exc));
    chk(t, "jump", 32'(jmp), 32'(e_jmp));
    chk(t, "base", 32'(base), 32'(m_base));
    chk(t, "mask", 32'(ws), 32'(m_ws));
    chk(t, "callinc", 32'(ci), 32'(m_ci));
    if (e_we) begin chk(t, "waddr", 32'(waddr), 32'(e_waddr)); chk(t, "wdata", wdata, e_wdata); end
    if (e_exc) begin chk(t, "cause", 32'(cause), 32'(e_cause)); chk(t, "epc", epc, e_epc); end
    if (e_exc && e_cause >= 3) chk(t, "owb", 32'(owb), 32'(e_owb));
    if (e_jmp) chk(t, "jpc", jpc, e_jpc);
  endtask

  // called on a falling edge; result checked on the next falling edge
  task automatic step(logic v, logic [1:0] o, string ovr = "");
    op_valid = v; op = o;
    model();
    if (ovr != "") tag = ovr;
    @(negedge clk);
    compare(tag);
    op_valid = 0;
  endtask

  task automatic rnd_fields();
    cinc = 2'($urandom); pc = $urandom; npc = $urandom; sval = $urandom;
    imm = 12'($urandom); link = $urandom;
    sidx = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 4);
    woe = ($urandom % 10 != 0); excm = ($urandom % 10 == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    dummy = $urandom(32'd20240601);
    m_base = 0; m_ws = 16'h0001; m_ci = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "base", 32'(base), 0); chk("R1", "mask", 32'(ws), 1);
    chk("R1", "callinc", 32'(ci), 0); chk("R1", "pulses", {29'd0, rf_we, exc, jmp}, 0);
    @(negedge clk);
    // R8/R10: return from frame 0 with n=1 wraps to frame 15, not live -> underflow
    woe = 1; excm = 0; pc = 32'hC000_1000; link = 32'h4000_0040;
    step(1, 2'd2, "R10");
    // R9: frame 15 base, nothing live under it except... frame 0 is above; 14,13,12 clear
    step(1, 2'd3, "R9");
    // R11 idle with garbage fields
    rnd_fields(); step(0, 2'd1, "R11");
    // rebuild: reset again
    rst_n = 0; m_base = 0; m_ws = 1; m_ci = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    woe = 1; excm = 0;
    // R2 call by 8, R5 entry, R7 return
    cinc = 2; npc = 32'h1234_5678; step(1, 2'd0, "R2");
    sidx = 1; imm = 12'd4; sval = 32'h100; step(1, 2'd1, "R5");
    link = 32'h8000_0ABC; pc = 32'h4000_0000; step(1, 2'd2, "R7");
    // R3 call increment 0
    cinc = 0; step(1, 2'd0, "R3");
    // R4 entry with bad index and with exception mode
    sidx = 4'd5; step(1, 2'd1, "R4");
    sidx = 0; excm = 1; step(1, 2'd1, "R4");
    excm = 0;
    // R6 return with n=0
    link = 32'h0000_0010; step(1, 2'd2, "R6");
    // R10 wrap on entry: rotate by 12 repeatedly
    cinc = 3; step(1, 2'd0, "R2");
    for (int i = 0; i < 6; i++) begin
      sidx = 1; step(1, 2'd1, "R10");
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      rnd_fields();
      step(($urandom % 8) != 0, 2'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule